// File: doc/BRIEF.md
# Two-step flash code assembler

This block is the digital back end of a subranging converter that reaches a 10-bit code in two flash passes over one shared bank of 16 comparators. A coarse estimator of six comparators first produces a rough position of the input. From that estimate the block computes which group of 16 upper-ladder taps the shared bank should be wired to, and drives that window base out. It then decodes the first pass into the six upper result bits and the second pass into the four lower bits. It latches the full code and raises a one-cycle done strobe.

The three comparator words arrive as thermometer codes. Each is captured by the strobe `cap_i` while the sequencer sits in the matching phase. The two passes share one 16-bit bus, because they come from the same comparators. Each word is decoded by counting its ones. A word that is not a clean run of ones from bit 0 is flagged, but it still yields a code. The selected tap window reaches one sixteenth of full scale past each edge of the estimator's bracket. Because of this, an estimator threshold error of up to 64 LSB does not change the final code.

Top module: `twostep_flash_asm`

## Requirements
- R1: After reset the phase is IDLE (0), and `win_base_o`, `code_o`, `done_o` and `bubble_o` are all 0.
- R2: Phases use the encoding IDLE=0, EST=1, MSB=2, LSB=3, LATCH=4. `start_i` moves IDLE to EST. `cap_i` moves EST to MSB, MSB to LSB and LSB to LATCH. LATCH returns to IDLE after one cycle without any input.
- R3: `start_i` has no effect outside IDLE. `cap_i` has no effect in IDLE. In EST, MSB and LSB the phase holds while `cap_i` is low.
- R4: A capture in EST sets `win_base_o` to 8 times the number of ones in `est_therm_i`, limited to 48, from the next cycle on. The value holds until the next EST capture.
- R5: A capture in MSB sets the upper six result bits to `win_base_o` plus the ones count of `pass_therm_i` minus 1, limited to the range 0 to 63.
- R6: A capture in LSB sets the lower four result bits to the ones count of `pass_therm_i` minus 1. A count of 0 gives 0, and the result is limited to 15.
- R7: `code_o` (upper bits in [9:4], lower bits in [3:0]) changes only on the edge that leaves LATCH. `done_o` is high for exactly the one cycle after LATCH.
- R8: A word is malformed when some bit is 1 while the bit below it is 0. `bubble_o` is updated together with `code_o`: it is 1 if any of the three captured words was malformed, and 0 otherwise.
- R9: All-zero words give code 0. All-ones words give code 1023.
- R10: For any input level, comparator words formed from that level give exactly that code, even when every estimator threshold is offset by up to ±64 LSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a conversion (accepted in IDLE) |
| cap_i | input | 1 | Capture the comparator word of the current phase |
| est_therm_i | input | 6 | Estimator thermometer word |
| pass_therm_i | input | 16 | Shared comparator bank word, first or second pass |
| phase_o | output | 3 | Current phase |
| win_base_o | output | 6 | Base of the selected upper-ladder tap window, in 1/64 of full scale |
| code_o | output | 10 | Latched conversion result |
| done_o | output | 1 | One-cycle strobe when a new result is latched |
| bubble_o | output | 1 | Malformed thermometer word seen in the latched conversion |

## Verification
The cycle that carries the done strobe of one conversion is also an IDLE cycle, so it can accept the start of the next conversion. The bench provokes this by raising `start_i` in the done cycle, running conversions back to back. A reference model is compared on every clock. It must show that the strobe, the new code and the move into EST all occur in that one cycle. It must also show that the new conversion leaves the just-latched code and bubble flag untouched until its own LATCH.

// File: rtl/tsf_pkg.sv
`timescale 1ns/1ps
package tsf_pkg;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_EST   = 3'd1,
        PH_MSB   = 3'd2,
        PH_LSB   = 3'd3,
        PH_LATCH = 3'd4
    } phase_e;

    // per-conversion record of malformed thermometer words
    typedef struct packed {
        logic est_bad;
        logic msb_bad;
        logic lsb_bad;
    } word_flags_t;

    function automatic int clamp_int(input int v, input int lo, input int hi);
        if (v < lo) return lo;
        if (v > hi) return hi;
        return v;
    endfunction

endpackage

// File: rtl/tsf_therm_decode.sv
`timescale 1ns/1ps
module tsf_therm_decode #(
    parameter int W  = 16,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  word_i,
    output logic [CW-1:0] count_o,
    output logic          bad_o
);
    logic [W-2:0] brk;

    // a 1 standing above a 0 breaks the thermometer run
    genvar g;
    generate
        for (g = 0; g < W - 1; g++) begin : g_pair
            assign brk[g] = word_i[g+1] & ~word_i[g];
        end
    endgenerate

    assign bad_o = |brk;

    always_comb begin
        count_o = '0;
        for (int i = 0; i < W; i++) begin
            count_o = count_o + CW'(word_i[i]);
        end
    end
endmodule

// File: rtl/tsf_phase_ctrl.sv
`timescale 1ns/1ps
module tsf_phase_ctrl
    import tsf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  logic   cap_i,
    output phase_e phase_o
);
    phase_e ph_q, ph_n;

    always_comb begin
        ph_n = ph_q;
        unique case (ph_q)
            PH_IDLE:  if (start_i) ph_n = PH_EST;
            PH_EST:   if (cap_i)   ph_n = PH_MSB;
            PH_MSB:   if (cap_i)   ph_n = PH_LSB;
            PH_LSB:   if (cap_i)   ph_n = PH_LATCH;
            PH_LATCH: ph_n = PH_IDLE;
            default:  ph_n = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_IDLE;
        else     ph_q <= ph_n;
    end

    assign phase_o = ph_q;

    // R2
    latch_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_LATCH) |=> (ph_q == PH_IDLE));
    // R2
    est_step_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_EST && cap_i) |=> (ph_q == PH_MSB));
    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ph_q == PH_IDLE && !start_i) |=> (ph_q == PH_IDLE));
    // R3
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((ph_q inside {PH_EST, PH_MSB, PH_LSB}) && !cap_i) |=> $stable(ph_q));
endmodule

// File: rtl/tsf_assemble.sv
`timescale 1ns/1ps
module tsf_assemble
    import tsf_pkg::*;
#(
    parameter int EST_W    = 6,
    parameter int PASS_W   = 16,
    parameter int MSB_W    = 6,
    parameter int LSB_W    = 4,
    parameter int WIN_STEP = 8,
    parameter int EC_W     = $clog2(EST_W + 1),
    parameter int PC_W     = $clog2(PASS_W + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  phase_e                 phase_i,
    input  logic                   cap_i,
    input  logic [EC_W-1:0]        est_cnt_i,
    input  logic                   est_bad_i,
    input  logic [PC_W-1:0]        pass_cnt_i,
    input  logic                   pass_bad_i,
    output logic [MSB_W-1:0]       win_base_o,
    output logic [MSB_W+LSB_W-1:0] code_o,
    output logic                   done_o,
    output logic                   bubble_o
);
    localparam int MSB_MAX = (1 << MSB_W) - 1;
    localparam int LSB_MAX = (1 << LSB_W) - 1;
    localparam int WIN_MAX = (1 << MSB_W) - PASS_W;
    localparam logic [MSB_W-1:0] WIN_MAX_V = MSB_W'(WIN_MAX);
    localparam logic [PC_W-1:0]  PASS_FULL = PC_W'(PASS_W);

    logic [MSB_W-1:0]       win_q, win_n, msb_q, msb_n;
    logic [LSB_W-1:0]       lsb_q, lsb_n;
    logic [MSB_W+LSB_W-1:0] code_q;
    logic                   done_q, bub_q;
    word_flags_t            flg_q;

    always_comb begin
        win_n = MSB_W'(clamp_int(int'(est_cnt_i) * WIN_STEP, 0, WIN_MAX));
        msb_n = MSB_W'(clamp_int(int'(win_q) + int'(pass_cnt_i) - 1, 0, MSB_MAX));
        lsb_n = LSB_W'(clamp_int(int'(pass_cnt_i) - 1, 0, LSB_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q  <= '0;
            msb_q  <= '0;
            lsb_q  <= '0;
            code_q <= '0;
            done_q <= 1'b0;
            bub_q  <= 1'b0;
            flg_q  <= '0;
        end else begin
            done_q <= 1'b0;
            unique case (phase_i)
                PH_EST: if (cap_i) begin
                    win_q         <= win_n;
                    flg_q.est_bad <= est_bad_i;
                end
                PH_MSB: if (cap_i) begin
                    msb_q         <= msb_n;
                    flg_q.msb_bad <= pass_bad_i;
                end
                PH_LSB: if (cap_i) begin
                    lsb_q         <= lsb_n;
                    flg_q.lsb_bad <= pass_bad_i;
                end
                PH_LATCH: begin
                    code_q <= {msb_q, lsb_q};
                    bub_q  <= |flg_q;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign win_base_o = win_q;
    assign code_o     = code_q;
    assign done_o     = done_q;
    assign bubble_o   = bub_q;

    // R4
    win_bound_chk: assert property (@(posedge clk) disable iff (rst)
        win_q <= WIN_MAX_V);
    // R4
    win_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(phase_i == PH_EST && cap_i) |=> $stable(win_q));
    // R5
    msb_floor_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_MSB && cap_i && pass_cnt_i == '0 && win_q == '0) |=> (msb_q == '0));
    // R6
    lsb_top_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i == PH_LSB && cap_i && pass_cnt_i == PASS_FULL) |=> (lsb_q == '1));
    // R7
    code_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (phase_i != PH_LATCH) |=> $stable(code_q));
    // R7
    done_src_chk: assert property (@(posedge clk) disable iff (rst)
        done_q |-> $past(phase_i == PH_LATCH));
endmodule

// File: rtl/twostep_flash_asm.sv
`timescale 1ns/1ps
module twostep_flash_asm
    import tsf_pkg::*;
#(
    parameter int EST_W    = 6,
    parameter int PASS_W   = 16,
    parameter int MSB_W    = 6,
    parameter int LSB_W    = 4,
    parameter int WIN_STEP = 8
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_i,
    input  logic                   cap_i,
    input  logic [EST_W-1:0]       est_therm_i,
    input  logic [PASS_W-1:0]      pass_therm_i,
    output logic [2:0]             phase_o,
    output logic [MSB_W-1:0]       win_base_o,
    output logic [MSB_W+LSB_W-1:0] code_o,
    output logic                   done_o,
    output logic                   bubble_o
);
    localparam int EC_W = $clog2(EST_W + 1);
    localparam int PC_W = $clog2(PASS_W + 1);

    phase_e          phase;
    logic [EC_W-1:0] est_cnt;
    logic [PC_W-1:0] pass_cnt;
    logic            est_bad, pass_bad;

    tsf_phase_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .cap_i   (cap_i),
        .phase_o (phase)
    );

    tsf_therm_decode #(.W(EST_W), .CW(EC_W)) u_est_dec (
        .word_i  (est_therm_i),
        .count_o (est_cnt),
        .bad_o   (est_bad)
    );

    // one decoder serves both passes: the comparator bank is shared
    tsf_therm_decode #(.W(PASS_W), .CW(PC_W)) u_pass_dec (
        .word_i  (pass_therm_i),
        .count_o (pass_cnt),
        .bad_o   (pass_bad)
    );

    tsf_assemble #(
        .EST_W(EST_W), .PASS_W(PASS_W), .MSB_W(MSB_W), .LSB_W(LSB_W),
        .WIN_STEP(WIN_STEP), .EC_W(EC_W), .PC_W(PC_W)
    ) u_asm (
        .clk        (clk),
        .rst        (rst),
        .phase_i    (phase),
        .cap_i      (cap_i),
        .est_cnt_i  (est_cnt),
        .est_bad_i  (est_bad),
        .pass_cnt_i (pass_cnt),
        .pass_bad_i (pass_bad),
        .win_base_o (win_base_o),
        .code_o     (code_o),
        .done_o     (done_o),
        .bubble_o   (bubble_o)
    );

    assign phase_o = phase;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/twostep_flash_asm_bench.sv
`timescale 1ns/1ps
module twostep_flash_asm_bench;
    logic        clk = 1'b0, rst = 1'b1, start_i = 1'b0, cap_i = 1'b0;
    logic [5:0]  est_i = '0;
    logic [15:0] pass_i = '0;
    logic [2:0]  phase_o;
    logic [5:0]  win_o;
    logic [9:0]  code_o;
    logic        done_o, bubble_o;

    twostep_flash_asm u_twostep_flash_asm (
        .clk(clk), .rst(rst), .start_i(start_i), .cap_i(cap_i),
        .est_therm_i(est_i), .pass_therm_i(pass_i),
        .phase_o(phase_o), .win_base_o(win_o), .code_o(code_o),
        .done_o(done_o), .bubble_o(bubble_o)
    );

    always #5 clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit cmp_en = 0, finished = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ones(input logic [15:0] w);
        int c = 0;
        for (int i = 0; i < 16; i++) if (w[i]) c++;
        return c;
    endfunction

    function automatic bit malformed(input logic [15:0] w, input int n);
        for (int i = 0; i < n - 1; i++) if (w[i+1] && !w[i]) return 1'b1;
        return 1'b0;
    endfunction

    function automatic int lim(input int v, input int lo, input int hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    // behavioural reference model, one step per clock
    int m_ph, m_win, m_msb, m_lsb, m_code, m_done, m_bub, m_eb, m_mb, m_lb;
    always @(posedge clk) begin
        if (rst) begin
            m_ph <= 0; m_win <= 0; m_msb <= 0; m_lsb <= 0; m_code <= 0;
            m_done <= 0; m_bub <= 0; m_eb <= 0; m_mb <= 0; m_lb <= 0;
        end else begin
            m_done <= 0;
            case (m_ph)
                0: if (start_i) m_ph <= 1;
                1: if (cap_i) begin
                    m_ph <= 2; m_win <= lim(8 * ones({10'b0, est_i}), 0, 48);
                    m_eb <= int'(malformed({10'b0, est_i}, 6));
                end
                2: if (cap_i) begin
                    m_ph <= 3; m_msb <= lim(m_win + ones(pass_i) - 1, 0, 63);
                    m_mb <= int'(malformed(pass_i, 16));
                end
                3: if (cap_i) begin
                    m_ph <= 4; m_lsb <= lim(ones(pass_i) - 1, 0, 15);
                    m_lb <= int'(malformed(pass_i, 16));
                end
                default: begin
                    m_ph <= 0; m_code <= m_msb * 16 + m_lsb;
                    m_bub <= (m_eb | m_mb | m_lb); m_done <= 1;
                end
            endcase
        end
    end

    always @(negedge clk) begin
        if (cmp_en && !finished) begin
            chk(int'(phase_o) == m_ph, "R2 phase (R3 when busy)", int'(phase_o), m_ph);
            chk(int'(win_o) == m_win, "R4 window base", int'(win_o), m_win);
            chk(int'(code_o) == m_code, "R7 code", int'(code_o), m_code);
            chk(int'(done_o) == m_done, "R7 done strobe", int'(done_o), m_done);
            chk(int'(bubble_o) == m_bub, "R8 bubble flag", int'(bubble_o), m_bub);
        end
    end

    task automatic step;
        @(negedge clk);
        #1;
    endtask

    // start is raised in the current cycle; returns in the done cycle
    task automatic run(input logic [5:0] e, input logic [15:0] a, input logic [15:0] b,
                       input int gap, input bit noise);
        start_i = 1'b1; step; start_i = 1'b0;
        repeat (gap) begin start_i = noise; step; end
        start_i = 1'b0; est_i = e; cap_i = 1'b1; step; cap_i = 1'b0;
        repeat (gap) begin start_i = noise; step; end
        start_i = 1'b0; pass_i = a; cap_i = 1'b1; step; cap_i = 1'b0;
        repeat (gap) begin start_i = noise; step; end
        start_i = 1'b0; pass_i = b; cap_i = 1'b1; step; cap_i = 1'b0;
        step;
    endtask

    // comparator words for an input level v with estimator offset off
    task automatic make_words(input int v, input int off, output logic [5:0] e,
                              output logic [15:0] a, output logic [15:0] b);
        int k = 0;
        int base, f, msb, r;
        for (int t = 0; t < 6; t++) if (v + off >= (2 * t + 3) * 64) k++;
        e = 6'((1 << k) - 1);
        base = lim(8 * k, 0, 48);
        a = '0;
        for (int i = 0; i < 16; i++) a[i] = (v >= (base + i) * 16);
        f = ones(a);
        msb = lim(base + f - 1, 0, 63);
        r = v - msb * 16;
        b = '0;
        for (int j = 0; j < 16; j++) b[j] = (r >= j);
    endtask

    initial begin
        int vals[9] = '{0, 5, 191, 200, 517, 640, 700, 1000, 1023};
        int offs[5] = '{0, 40, -40, 64, -64};
        logic [5:0]  we;
        logic [15:0] wa, wb;

        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1 rst = 1'b0;
        cmp_en = 1'b1;
        step;
        chk(phase_o == 3'd0, "R1 phase after reset", int'(phase_o), 0);
        chk(code_o == 10'd0, "R1 code after reset", int'(code_o), 0);
        chk(!done_o && !bubble_o && win_o == 6'd0, "R1 flags after reset",
            int'({done_o, bubble_o}), 0);

        // capture strobe while idle
        est_i = 6'h3f; cap_i = 1'b1; step; cap_i = 1'b0;
        chk(phase_o == 3'd0, "R3 cap in idle phase", int'(phase_o), 0);
        chk(win_o == 6'd0, "R3 cap in idle window", int'(win_o), 0);

        run(6'h00, 16'h0000, 16'h0000, 0, 0);
        chk(code_o == 10'd0, "R9 all zero", int'(code_o), 0);
        chk(done_o == 1'b1, "R7 done after latch", int'(done_o), 1);
        run(6'h3f, 16'hffff, 16'hffff, 0, 0);   // start in the done cycle
        chk(code_o == 10'd1023, "R9 all ones", int'(code_o), 1023);
        chk(win_o == 6'd48, "R4 top window", int'(win_o), 48);
        step;
        chk(!done_o && code_o == 10'd1023, "R7 done one cycle, code held",
            int'(done_o), 0);

        run(6'h03, 16'h0000, 16'hffff, 1, 0);
        chk(code_o == 10'd255, "R5 below window", int'(code_o), 255);
        run(6'h00, 16'h0000, 16'h000f, 0, 0);
        chk(code_o == 10'd3, "R5 clamp at zero", int'(code_o), 3);
        run(6'h00, 16'h0003, 16'hffff, 0, 0);
        chk(code_o == 10'd31, "R6 full second pass", int'(code_o), 31);
        run(6'h00, 16'h0001, 16'h0000, 2, 1);
        chk(code_o == 10'd0, "R6 empty second pass", int'(code_o), 0);
        chk(win_o == 6'd0, "R4 base zero", int'(win_o), 0);

        run(6'h05, 16'h00ff, 16'h0007, 1, 1);
        chk(bubble_o == 1'b1, "R8 estimator bubble", int'(bubble_o), 1);
        chk(code_o == 10'd370, "R8 code despite bubble", int'(code_o), 370);
        run(6'h00, 16'h0101, 16'h0001, 0, 0);
        chk(bubble_o == 1'b1 && code_o == 10'd16, "R8 pass bubble",
            int'(code_o), 16);
        run(6'h1f, 16'h00ff, 16'h0001, 2, 1);
        chk(bubble_o == 1'b0, "R8 clean clears flag", int'(bubble_o), 0);
        chk(win_o == 6'd40, "R4 window from five ones", int'(win_o), 40);
        chk(code_o == 10'd752, "R3 start during busy ignored", int'(code_o), 752);

        foreach (vals[i]) begin
            foreach (offs[j]) begin
                make_words(vals[i], offs[j], we, wa, wb);
                run(we, wa, wb, (i + j) % 2, 1'b0);
                chk(int'(code_o) == vals[i], "R10 offset estimate corrected",
                    int'(code_o), vals[i]);
            end
        end

        step;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL R2 watchdog actual=running expected=complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule